// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port of a memory device. A four-wire serial port (test clock, mode select, serial data in, serial data out) walks the standard sixteen-state controller. Through that port the tester loads a 3-bit instruction and then scans one of three data registers. The choices are a 1-bit bypass stage, a 32-bit identification word, or a chain of boundary cells. The boundary chain is 107 cells by default. Its cells capture the device's parallel pin values and drive parallel update values.

Two mode outputs tell the surrounding pad logic what to do. One says that the boundary update latches own the pins (external test). The other forces the device's data outputs to high impedance while the pins are sampled. All shifting and capture happen on the rising test clock edge. The serial output, the instruction update and the boundary update change on the falling edge.

The block also has a synchronous active-high reset that stands in for the power-up reset. There is no separate test-reset pin; holding mode select high brings the controller home. The pad must pull mode select and serial data in up, so that an undriven wire reads as 1.

Top module: `scan_tap`

## Requirements
- R1: The controller follows the standard sixteen-state test-port state diagram on the rising test clock. Reset puts it in Test-Logic-Reset. Five rising edges with mode select high reach Test-Logic-Reset from any state, including the middle of a data shift.
- R2: Entering Test-Logic-Reset makes IDCODE the active instruction. A data scan then returns the 32-bit identification word, least significant bit first. The word holds revision 3'b000 in bits 31:29, the device code in bits 28:12, vendor code 0x033 in bits 11:1, and a 1 in bit 0.
- R3: In Capture-IR the instruction shift register loads 3'b001, so an instruction scan shows 1, 0, 0 on serial out first.
- R4: The instruction codes are: 000 external test, 001 IDCODE, 010 sample with outputs forced to high impedance, 100 sample/preload, 111 bypass. The shifted value becomes active on the falling edge in Update-IR.
- R5: Bypass (111) and the reserved codes 011, 101 and 110 select the 1-bit bypass stage. It captures 0, so serial out gives 0 and then each serial-in bit one clock late.
- R6: Under codes 000, 010 and 100, Capture-DR loads `bs_pin_in` into the boundary chain. The chain shifts out bit 0 first, and serial-in enters bit BSR_LEN-1.
- R7: Update-DR under codes 000, 010 or 100 copies the boundary chain to `bs_pin_out` on the falling edge. A data scan under any other instruction leaves `bs_pin_out` unchanged, and Test-Logic-Reset clears it to 0.
- R8: `out_hiz` is 1 exactly while code 010 is active. `bs_extest` is 1 exactly while code 000 is active.
- R9: Serial out changes on the falling test clock edge. `tdo_oe` is 1 only in Shift-DR and Shift-IR; elsewhere it is 0 and `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| bs_pin_in | input | BSR_LEN | Parallel pin values captured by the boundary chain |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | Serial output enable |
| bs_pin_out | output | BSR_LEN | Boundary update latches |
| bs_extest | output | 1 | Boundary latches drive the pins |
| out_hiz | output | 1 | Force device data outputs to high impedance |

## Verification
The bench keeps the default 107-cell chain, so a full boundary scan exercises the real chain length and the placement of the last bit. It overrides the device code with the irregular pattern 17'h1A5C3. This makes a misplaced or reversed identification field show up as a wrong bit rather than a lucky match. The random sweep draws from all eight instruction codes, so the three reserved codes and every register selection are reached alongside directed reset-during-shift and synchronous-reset cases.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    localparam int IR_W = 3;
    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPZ   = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_t;

    typedef struct packed {
        logic    hiz;
        logic    extest;
        dr_sel_t sel;
    } op_ctrl_t;

    function automatic tap_state_t tap_next(tap_state_t s, logic m);
        tap_state_t n;
        case (s)
            ST_TLR:    n = m ? ST_TLR    : ST_RTI;
            ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    function automatic op_ctrl_t op_decode(logic [IR_W-1:0] op);
        op_ctrl_t c;
        c.hiz    = (op == OP_SAMPZ);
        c.extest = (op == OP_EXTEST);
        case (op)
            OP_IDCODE:                      c.sel = SEL_ID;
            OP_EXTEST, OP_SAMPZ, OP_SAMPLE: c.sel = SEL_BSR;
            default:                        c.sel = SEL_BYP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_t state
);

    always_ff @(posedge tck) begin
        if (rst) state <= ST_TLR;
        else     state <= tap_next(state, tms);
    end

    // R1
    tlr_hold_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_TLR && tms) |=> state == ST_TLR);

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  logic            tdi,
    input  tap_state_t      state,
    output logic            ir_so,
    output logic [IR_W-1:0] act_op
);

    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge tck) begin
        if (rst)
            ir_sh <= IR_CAPTURE;
        else if (state == ST_CAP_IR)
            ir_sh <= IR_CAPTURE;
        else if (state == ST_SH_IR)
            ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    always_ff @(negedge tck) begin
        if (rst || state == ST_TLR)
            act_op <= OP_IDCODE;
        else if (state == ST_UPD_IR)
            act_op <= ir_sh;
    end

    assign ir_so = ir_sh[0];

    // R3
    ir_cap_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_CAP_IR) |=> ir_sh == IR_CAPTURE);

    // R4
    ir_upd_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_UPD_IR) |=> act_op == $past(ir_sh));

    // R2
    ir_tlr_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_TLR) |=> act_op == OP_IDCODE);

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN = 107,
    parameter logic [31:0] ID_WORD = 32'h0000_0067
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tdi,
    input  tap_state_t         state,
    input  dr_sel_t            sel,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               dr_so,
    output logic [BSR_LEN-1:0] pin_out
);

    logic               byp_q;
    logic [31:0]        id_sh;
    logic [BSR_LEN-1:0] bsr_sh;

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q  <= 1'b0;
            id_sh  <= '0;
            bsr_sh <= '0;
        end else if (state == ST_CAP_DR) begin
            case (sel)
                SEL_ID:  id_sh  <= ID_WORD;
                SEL_BSR: bsr_sh <= pin_in;
                default: byp_q  <= 1'b0;
            endcase
        end else if (state == ST_SH_DR) begin
            case (sel)
                SEL_ID:  id_sh  <= {tdi, id_sh[31:1]};
                SEL_BSR: bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
                default: byp_q  <= tdi;
            endcase
        end
    end

    always_ff @(negedge tck) begin
        if (rst || state == ST_TLR)
            pin_out <= '0;
        else if (state == ST_UPD_DR && sel == SEL_BSR)
            pin_out <= bsr_sh;
    end

    always_comb begin
        case (sel)
            SEL_ID:  dr_so = id_sh[0];
            SEL_BSR: dr_so = bsr_sh[0];
            default: dr_so = byp_q;
        endcase
    end

    // R5
    byp_cap_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_CAP_DR && sel == SEL_BYP) |=> byp_q == 1'b0);

    // R6
    bsr_cap_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_CAP_DR && sel == SEL_BSR) |=> bsr_sh == $past(pin_in));

    // R7
    pin_hold_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_UPD_DR && sel != SEL_BYP && sel != SEL_BSR) |=> $stable(pin_out));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN = 107,
    parameter logic [16:0] DEV_ID  = 17'h00123,
    parameter logic [10:0] VENDOR  = 11'h033,
    parameter logic [2:0]  REV     = 3'h0
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] bs_pin_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [BSR_LEN-1:0] bs_pin_out,
    output logic               bs_extest,
    output logic               out_hiz
);

    localparam logic [31:0] ID_WORD = {REV, DEV_ID, VENDOR, 1'b1};

    tap_state_t      fsm_state;
    logic [IR_W-1:0] act_op;
    logic            ir_so;
    logic            dr_so;
    op_ctrl_t        ctrl;

    scan_tap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (fsm_state)
    );

    scan_tap_ir u_ir (
        .tck    (tck),
        .rst    (rst),
        .tdi    (tdi),
        .state  (fsm_state),
        .ir_so  (ir_so),
        .act_op (act_op)
    );

    assign ctrl = op_decode(act_op);

    scan_tap_dr #(.BSR_LEN(BSR_LEN), .ID_WORD(ID_WORD)) u_dr (
        .tck     (tck),
        .rst     (rst),
        .tdi     (tdi),
        .state   (fsm_state),
        .sel     (ctrl.sel),
        .pin_in  (bs_pin_in),
        .dr_so   (dr_so),
        .pin_out (bs_pin_out)
    );

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            case (fsm_state)
                ST_SH_DR: begin tdo <= dr_so; tdo_oe <= 1'b1; end
                ST_SH_IR: begin tdo <= ir_so; tdo_oe <= 1'b1; end
                default:  begin tdo <= 1'b0;  tdo_oe <= 1'b0; end
            endcase
        end
    end

    assign bs_extest = ctrl.extest;
    assign out_hiz   = ctrl.hiz;

    // R9
    tdo_en_chk: assert property (@(posedge tck) disable iff (rst)
        tdo_oe == (fsm_state == ST_SH_DR || fsm_state == ST_SH_IR));

    // R8
    mode_tlr_chk: assert property (@(posedge tck) disable iff (rst)
        (fsm_state == ST_TLR) |=> (!out_hiz && !bs_extest));

    // R8
    mode_excl_chk: assert property (@(posedge tck) disable iff (rst)
        !(out_hiz && bs_extest));

endmodule

// File: tb/sim_scan_tap.sv
module sim_scan_tap;

    localparam int          TCK_P  = 20;
    localparam int          BSR    = 107;
    localparam logic [16:0] DEV    = 17'h1A5C3;
    localparam logic [10:0] VEN    = 11'h033;
    localparam logic [31:0] ID_EXP = {3'b000, DEV, VEN, 1'b1};

    logic           tck = 1'b0;
    logic           rst = 1'b1;
    logic           tms = 1'b1;
    logic           tdi = 1'b1;
    logic [BSR-1:0] pin_in = '0;
    logic           tdo, tdo_oe, bs_extest, out_hiz;
    logic [BSR-1:0] pin_out;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #(TCK_P/2) tck = ~tck;

    scan_tap #(.BSR_LEN(BSR), .DEV_ID(DEV), .VENDOR(VEN)) u0 (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .bs_pin_in(pin_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .bs_pin_out(pin_out),
        .bs_extest(bs_extest), .out_hiz(out_hiz)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // one TCK: sample serial out after the falling edge, then drive for the rising edge
    task automatic tick(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck); #1;
        o = tdo; e = tdo_oe;
        tms = m; tdi = d;
        @(posedge tck); #1;
    endtask

    task automatic go_idle();
        logic o, e;
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, o, e);
        tick(1'b0, 1'b1, o, e);
    endtask

    task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap, output bit oe_ok);
        logic o, e;
        oe_ok = 1;
        tick(1, 0, o, e); tick(1, 0, o, e); tick(0, 0, o, e); tick(0, 0, o, e);
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, code[i], o, e);
            cap[i] = o;
            if (e !== 1'b1) oe_ok = 0;
        end
        tick(1, 0, o, e); tick(0, 0, o, e);
    endtask

    task automatic scan_dr(input int n, input logic [127:0] din,
                           output logic [127:0] dout, output bit oe_ok);
        logic o, e;
        oe_ok = 1;
        dout = '0;
        tick(1, 0, o, e); tick(0, 0, o, e); tick(0, 0, o, e);
        for (int i = 0; i < n; i++) begin
            tick(i == n-1, din[i], o, e);
            dout[i] = o;
            if (e !== 1'b1) oe_ok = 0;
        end
        tick(1, 0, o, e); tick(0, 0, o, e);
    endtask

    function automatic int exp_sel(input logic [2:0] c);
        case (c)
            3'b001:                 return 1;
            3'b000, 3'b010, 3'b100: return 2;
            default:                return 0;
        endcase
    endfunction

    function automatic int exp_len(input int s);
        return (s == 0) ? 8 : (s == 1) ? 32 : BSR;
    endfunction

    function automatic logic [127:0] exp_dout(input int s, input int n,
                                              input logic [127:0] din, input logic [BSR-1:0] pins);
        logic [127:0] mask;
        mask = (128'd1 << n) - 128'd1;
        if (s == 0) return {din[126:0], 1'b0} & mask;
        if (s == 1) return {96'd0, ID_EXP};
        return {21'd0, pins};
    endfunction

    function automatic logic [BSR-1:0] rnd_bsr();
        logic [127:0] v;
        v = {$urandom, $urandom, $urandom, $urandom};
        return v[BSR-1:0];
    endfunction

    initial begin
        #(TCK_P * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0]   cap;
        logic [127:0] dout, din;
        logic [BSR-1:0] pout_exp;
        logic o, e;
        bit   ok;
        void'($urandom(32'd1357));

        repeat (3) @(posedge tck);
        #1 rst = 1'b0;
        @(negedge tck); #1;
        // R9 R7 R8: reset state
        chk("R9 oe after reset", {127'd0, tdo_oe}, 128'd0);
        chk("R7 pins after reset", {21'd0, pin_out}, 128'd0);
        chk("R8 modes after reset", {126'd0, out_hiz, bs_extest}, 128'd0);
        go_idle();
        tick(0, 0, o, e);
        chk("R9 oe idle", {126'd0, e, o}, 128'd0);

        // R2: IDCODE after reset
        scan_dr(32, 128'd0, dout, ok);
        chk("R2 id word", dout, {96'd0, ID_EXP});
        chk("R9 oe in shift", {127'd0, ok}, 128'd1);

        // R3 R4 R5: explicit bypass
        scan_ir(3'b111, cap, ok);
        chk("R3 ir capture", {125'd0, cap}, 128'd1);
        din = 128'hA5;
        scan_dr(8, din, dout, ok);
        chk("R5 bypass", dout, 128'h4A);

        // R6 R7 R8: SAMPLE/PRELOAD
        pin_in = rnd_bsr();
        scan_ir(3'b100, cap, ok);
        chk("R8 sample no hiz", {126'd0, out_hiz, bs_extest}, 128'd0);
        din = {21'd0, rnd_bsr()};
        scan_dr(BSR, din, dout, ok);
        chk("R6 sample capture", dout, {21'd0, pin_in});
        chk("R7 preload", {21'd0, pin_out}, din);
        pout_exp = din[BSR-1:0];

        // R1: five TMS-high edges from inside Shift-DR, then R2 R7 R8
        scan_ir(3'b010, cap, ok);
        chk("R8 sample-z hiz", {126'd0, out_hiz, bs_extest}, 128'd2);
        tick(1, 0, o, e); tick(0, 0, o, e); tick(0, 0, o, e); tick(0, 1, o, e);
        for (int i = 0; i < 5; i++) tick(1, 1, o, e);
        @(negedge tck); #1;
        chk("R1 tms reset clears hiz", {127'd0, out_hiz}, 128'd0);
        chk("R7 tlr clears pins", {21'd0, pin_out}, 128'd0);
        tick(0, 0, o, e);
        scan_dr(32, 128'd0, dout, ok);
        chk("R2 id after tms reset", dout, {96'd0, ID_EXP});

        // R1: synchronous reset while EXTEST is active
        scan_ir(3'b000, cap, ok);
        chk("R8 extest flag", {126'd0, out_hiz, bs_extest}, 128'd1);
        @(negedge tck); rst = 1'b1;
        @(posedge tck); #1 rst = 1'b0;
        @(negedge tck); #1;
        chk("R1 sync reset", {126'd0, out_hiz, bs_extest}, 128'd0);
        go_idle();
        pout_exp = '0;

        // random sweep over all codes (R4 R5 R6 R7 R8)
        for (int it = 0; it < 40; it++) begin
            logic [2:0] code;
            int s, n;
            code = 3'($urandom % 8);
            s = exp_sel(code);
            n = exp_len(s);
            pin_in = rnd_bsr();
            din = {$urandom, $urandom, $urandom, $urandom};
            if (n < 128) din = din & ((128'd1 << n) - 128'd1);
            scan_ir(code, cap, ok);
            chk("R3 ir capture rnd", {125'd0, cap}, 128'd1);
            chk("R8 modes rnd", {126'd0, out_hiz, bs_extest},
                {126'd0, code == 3'b010, code == 3'b000});
            scan_dr(n, din, dout, ok);
            chk(s == 0 ? "R5 bypass rnd" : s == 1 ? "R4 idcode rnd" : "R6 bsr rnd",
                dout, exp_dout(s, n, din, pin_in));
            chk("R9 oe rnd", {127'd0, ok}, 128'd1);
            if (s == 2) pout_exp = din[BSR-1:0];
            chk("R7 pin update rnd", {21'd0, pin_out}, {21'd0, pout_exp});
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule